// File: doc/BRIEF.md
# SD Host Vendor Register Front End

This block is the memory-mapped front end of an SD host controller. A host issues 32-bit accesses into a 4 KiB window. The lowest 256 bytes form a bank of 64 vendor words, and a few of those words carry special write behaviour:

- a control word whose only active bit requests a software reset;
- a PHY access port whose acknowledge bit follows its request bits;
- an eMMC control word whose tuning bit never stays set.

A 256-byte window starting at byte 0x200 is forwarded to a subordinate slot register port, which holds the standard slot registers. The block also drives a reset pulse to that slot and passes the slot interrupt straight through to its own interrupt output.

Host requests use a valid/ready handshake. The block raises `hst_req_ready` only while no slot access is outstanding, so a host may hold `hst_req_valid` with stable payload for as long as it likes. There is exactly one response pulse (`hst_rsp_valid`) per accepted request, in acceptance order. That response carries no back-pressure: the host must take it in the cycle it appears.

The slot port also uses valid/ready. Once `slot_req_valid` rises, it and its payload stay stable until the slot raises `slot_req_ready`. The slot places read data on `slot_rsp_rdata` in the same cycle as `slot_req_ready`.

Top module: `sdhost_regfront`

## Requirements
- R1: While `rst_n` is low and until the first clock edge after its release, `slot_rst` is 1. After reset, a read of byte 0x000 returns 0x00010000 and every other vendor word reads 0.
- R2: A write to any vendor word other than bytes 0x000, 0x010 and 0x018 stores all 32 bits, and a later read returns them unchanged.
- R3: A write to byte 0x000 with bit 0 clear changes nothing, and byte 0x000 always reads 0x00010000, so bit 0 reads back as 0.
- R4: A write to byte 0x000 with bit 0 set does two things:
  - it returns every vendor word to its reset value;
  - it makes `slot_rst` 1 for exactly the one cycle after the accepting edge.
- R5: A write to byte 0x010 stores the written value, except for bit 26. Bit 26 is stored as the OR of written bits 24 and 25; a written bit 26 itself is discarded.
- R6: A write to byte 0x018 stores the written value with bit 15 forced to 0.
- R7: An access to bytes 0x200–0x2FF is forwarded to the slot port.
  - The port carries the byte offset minus 0x200, the write flag and the write data.
  - That payload and `slot_req_valid` stay stable until `slot_req_ready`.
  - `hst_req_ready` is 0 while the slot access is pending.
- R8: The host response to a slot access appears in the cycle after the slot handshake. It carries `slot_rsp_rdata` for a read and 0 for a write, with `hst_rsp_err` = 0.
- R9: Some accesses are outside the decoded ranges:
  - bytes 0x100–0x1FF and 0x300–0xFFF;
  - any address whose two low bits are not 00.
  
  Such an access changes no state, returns read data 0 and sets `hst_rsp_err` = 1 with its response.
- R10: `host_irq` equals `slot_irq` at all times.
- R11: Vendor and unmapped accesses get their response (`hst_rsp_valid` = 1) in the cycle right after the accepting edge. A vendor read returns the word as it stood before that edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| hst_req_valid | input | 1 | Host request valid |
| hst_req_ready | output | 1 | Host request accepted when high with valid |
| hst_req_write | input | 1 | 1 = write, 0 = read |
| hst_req_addr | input | 12 | Byte address in the window |
| hst_req_wdata | input | 32 | Write data |
| hst_rsp_valid | output | 1 | One-cycle response pulse |
| hst_rsp_rdata | output | 32 | Read data (0 for writes) |
| hst_rsp_err | output | 1 | Access hit no decoded range or was misaligned |
| slot_req_valid | output | 1 | Slot access valid |
| slot_req_ready | input | 1 | Slot accepts access |
| slot_req_write | output | 1 | Slot access is a write |
| slot_req_addr | output | 8 | Byte offset inside the slot window |
| slot_req_wdata | output | 32 | Slot write data |
| slot_rsp_rdata | input | 32 | Slot read data, valid with slot_req_ready |
| slot_irq | input | 1 | Slot interrupt |
| slot_rst | output | 1 | Slot reset pulse |
| host_irq | output | 1 | Interrupt to the system |

## Verification
- **Vendor and unmapped accesses.** The response is due one cycle after the accepting edge. The scoreboard stamps each expected item with the cycle of that edge, and the monitor samples at the falling edge and demands that exact cycle.
- **Slot accesses.** The response is due one cycle after the slot handshake, and the slot model stalls for a chosen number of cycles. The bench therefore compares slot response data in order without a fixed stamp, and checks at the falling edge after acceptance that the host port is stalled.
- **`slot_rst`.** It is sampled at the two falling edges following a software-reset write: it must be 1 at the first and 0 at the second.

// File: rtl/sdrf_pkg.sv
package sdrf_pkg;

  typedef enum logic [1:0] {
    TGT_VENDOR = 2'd0,
    TGT_SLOT   = 2'd1,
    TGT_NONE   = 2'd2
  } tgt_e;

  // Vendor word indices whose behaviour is special.
  localparam int IDX_CTRL = 0;   // byte 0x000: software reset
  localparam int IDX_PHY  = 4;   // byte 0x010: PHY access port
  localparam int IDX_EMMC = 6;   // byte 0x018: eMMC control

  localparam int BIT_SWRST  = 0;
  localparam int BIT_PHY_WR = 24;
  localparam int BIT_PHY_RD = 25;
  localparam int BIT_PHY_AK = 26;
  localparam int BIT_TUNE   = 15;

  localparam logic [31:0] CTRL_RESET_VAL = 32'h0001_0000;

endpackage

// File: rtl/sdrf_decode.sv
module sdrf_decode
  import sdrf_pkg::*;
#(
  parameter int ADDR_W     = 12,
  parameter int VREG_BYTES = 256,
  parameter int SLOT_BASE  = 'h200,
  parameter int SLOT_SPAN  = 'h100,
  localparam int VIDX_W    = $clog2(VREG_BYTES / 4),
  localparam int SLOT_AW   = $clog2(SLOT_SPAN)
) (
  input  logic [ADDR_W-1:0]  addr,
  output tgt_e               tgt,
  output logic [VIDX_W-1:0]  vidx,
  output logic [SLOT_AW-1:0] slot_off
);

  logic aligned, in_vendor, in_slot;

  always_comb begin
    aligned   = (addr[1:0] == 2'b00);
    in_vendor = (32'(addr) < VREG_BYTES);
    in_slot   = (32'(addr) >= SLOT_BASE) && (32'(addr) < SLOT_BASE + SLOT_SPAN);
    if (!aligned)       tgt = TGT_NONE;
    else if (in_vendor) tgt = TGT_VENDOR;
    else if (in_slot)   tgt = TGT_SLOT;
    else                tgt = TGT_NONE;
  end

  assign vidx     = addr[VIDX_W+1:2];
  assign slot_off = SLOT_AW'(addr - ADDR_W'(SLOT_BASE));

endmodule

// File: rtl/sdrf_vendor_regs.sv
module sdrf_vendor_regs
  import sdrf_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int WORDS  = 64,
  localparam int IDX_W = $clog2(WORDS)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [IDX_W-1:0]  widx,
  input  logic [DATA_W-1:0] wdata,
  input  logic [IDX_W-1:0]  ridx,
  output logic [DATA_W-1:0] rdata,
  output logic              soft_rst
);

  logic [DATA_W-1:0] words [WORDS];

  // Software reset is requested by a control-word write with its low bit set.
  assign soft_rst = wr_en && (widx == IDX_W'(IDX_CTRL)) && wdata[BIT_SWRST];

  for (genvar i = 0; i < WORDS; i++) begin : g_word
    if (i == IDX_CTRL) begin : g_ctrl
      // The only writable bit self-clears, so the word never departs from its reset value.
      assign words[i] = DATA_W'(CTRL_RESET_VAL);
    end else begin : g_rw
      logic [DATA_W-1:0] q;
      logic [DATA_W-1:0] nxt;

      always_comb begin
        nxt = wdata;
        if (i == IDX_PHY)  nxt[BIT_PHY_AK] = wdata[BIT_PHY_WR] | wdata[BIT_PHY_RD];
        if (i == IDX_EMMC) nxt[BIT_TUNE]   = 1'b0;
      end

      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)                                   q <= '0;
        else if (soft_rst)                            q <= '0;
        else if (wr_en && (widx == IDX_W'(i)))        q <= nxt;
      end

      assign words[i] = q;
    end
  end

  assign rdata = words[ridx];

endmodule

// File: rtl/sdrf_slot_bridge.sv
module sdrf_slot_bridge #(
  parameter int DATA_W  = 32,
  parameter int SLOT_AW = 8
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               start,
  input  logic               start_write,
  input  logic [SLOT_AW-1:0] start_off,
  input  logic [DATA_W-1:0]  start_wdata,
  output logic               busy,
  output logic               done,
  output logic               done_write,
  output logic [DATA_W-1:0]  done_rdata,
  output logic               slot_req_valid,
  input  logic               slot_req_ready,
  output logic               slot_req_write,
  output logic [SLOT_AW-1:0] slot_req_addr,
  output logic [DATA_W-1:0]  slot_req_wdata,
  input  logic [DATA_W-1:0]  slot_rsp_rdata
);

  logic               vld_q;
  logic               wr_q;
  logic [SLOT_AW-1:0] off_q;
  logic [DATA_W-1:0]  wd_q;

  // Payload is captured once at start and held until the slot handshakes.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      vld_q <= 1'b0;
      wr_q  <= 1'b0;
      off_q <= '0;
      wd_q  <= '0;
    end else if (start) begin
      vld_q <= 1'b1;
      wr_q  <= start_write;
      off_q <= start_off;
      wd_q  <= start_wdata;
    end else if (vld_q && slot_req_ready) begin
      vld_q <= 1'b0;
    end
  end

  assign busy           = vld_q;
  assign done           = vld_q && slot_req_ready;
  assign done_write     = wr_q;
  assign done_rdata     = slot_rsp_rdata;
  assign slot_req_valid = vld_q;
  assign slot_req_write = wr_q;
  assign slot_req_addr  = off_q;
  assign slot_req_wdata = wd_q;

endmodule

// File: rtl/sdhost_regfront.sv
module sdhost_regfront
  import sdrf_pkg::*;
#(
  parameter int ADDR_W     = 12,
  parameter int DATA_W     = 32,
  parameter int VREG_BYTES = 256,
  parameter int SLOT_BASE  = 'h200,
  parameter int SLOT_SPAN  = 'h100
) (
  input  logic                         clk,
  input  logic                         rst_n,
  input  logic                         hst_req_valid,
  output logic                         hst_req_ready,
  input  logic                         hst_req_write,
  input  logic [ADDR_W-1:0]            hst_req_addr,
  input  logic [DATA_W-1:0]            hst_req_wdata,
  output logic                         hst_rsp_valid,
  output logic [DATA_W-1:0]            hst_rsp_rdata,
  output logic                         hst_rsp_err,
  output logic                         slot_req_valid,
  input  logic                         slot_req_ready,
  output logic                         slot_req_write,
  output logic [$clog2(SLOT_SPAN)-1:0] slot_req_addr,
  output logic [DATA_W-1:0]            slot_req_wdata,
  input  logic [DATA_W-1:0]            slot_rsp_rdata,
  input  logic                         slot_irq,
  output logic                         slot_rst,
  output logic                         host_irq
);

  localparam int VWORDS  = VREG_BYTES / 4;
  localparam int VIDX_W  = $clog2(VWORDS);
  localparam int SLOT_AW = $clog2(SLOT_SPAN);

  tgt_e               tgt;
  logic [VIDX_W-1:0]  vidx;
  logic [SLOT_AW-1:0] slot_off;
  logic               accept;
  logic               v_wr;
  logic [DATA_W-1:0]  v_rdata;
  logic               soft_rst;
  logic               busy;
  logic               s_done;
  logic               s_done_wr;
  logic [DATA_W-1:0]  s_rdata;

  logic               rsp_v_q;
  logic [DATA_W-1:0]  rsp_d_q;
  logic               rsp_e_q;
  logic               srst_q;

  sdrf_decode #(
    .ADDR_W(ADDR_W), .VREG_BYTES(VREG_BYTES),
    .SLOT_BASE(SLOT_BASE), .SLOT_SPAN(SLOT_SPAN)
  ) u_dec (
    .addr(hst_req_addr), .tgt(tgt), .vidx(vidx), .slot_off(slot_off)
  );

  assign hst_req_ready = !busy;
  assign accept        = hst_req_valid && hst_req_ready;
  assign v_wr          = accept && hst_req_write && (tgt == TGT_VENDOR);

  sdrf_vendor_regs #(.DATA_W(DATA_W), .WORDS(VWORDS)) u_vregs (
    .clk(clk), .rst_n(rst_n),
    .wr_en(v_wr), .widx(vidx), .wdata(hst_req_wdata),
    .ridx(vidx), .rdata(v_rdata), .soft_rst(soft_rst)
  );

  sdrf_slot_bridge #(.DATA_W(DATA_W), .SLOT_AW(SLOT_AW)) u_bridge (
    .clk(clk), .rst_n(rst_n),
    .start(accept && (tgt == TGT_SLOT)),
    .start_write(hst_req_write), .start_off(slot_off), .start_wdata(hst_req_wdata),
    .busy(busy), .done(s_done), .done_write(s_done_wr), .done_rdata(s_rdata),
    .slot_req_valid(slot_req_valid), .slot_req_ready(slot_req_ready),
    .slot_req_write(slot_req_write), .slot_req_addr(slot_req_addr),
    .slot_req_wdata(slot_req_wdata), .slot_rsp_rdata(slot_rsp_rdata)
  );

  // Response register: local targets answer one cycle after acceptance,
  // slot accesses one cycle after the slot handshake.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rsp_v_q <= 1'b0;
      rsp_d_q <= '0;
      rsp_e_q <= 1'b0;
    end else begin
      rsp_v_q <= 1'b0;
      rsp_d_q <= '0;
      rsp_e_q <= 1'b0;
      if (accept && (tgt != TGT_SLOT)) begin
        rsp_v_q <= 1'b1;
        rsp_e_q <= (tgt == TGT_NONE);
        if ((tgt == TGT_VENDOR) && !hst_req_write) rsp_d_q <= v_rdata;
      end else if (s_done) begin
        rsp_v_q <= 1'b1;
        if (!s_done_wr) rsp_d_q <= s_rdata;
      end
    end
  end

  // Slot reset: held through system reset, then pulsed once per software reset.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) srst_q <= 1'b1;
    else        srst_q <= soft_rst;
  end

  assign hst_rsp_valid = rsp_v_q;
  assign hst_rsp_rdata = rsp_d_q;
  assign hst_rsp_err   = rsp_e_q;
  assign slot_rst      = srst_q;
  assign host_irq      = slot_irq;

endmodule

// File: rtl/sdrf_checker.sv
module sdrf_checker #(
  parameter int ADDR_W    = 12,
  parameter int DATA_W    = 32,
  parameter int SLOT_BASE = 'h200,
  parameter int SLOT_SPAN = 'h100
) (
  input logic                         clk,
  input logic                         rst_n,
  input logic                         hst_req_valid,
  input logic                         hst_req_ready,
  input logic                         hst_req_write,
  input logic [ADDR_W-1:0]            hst_req_addr,
  input logic [DATA_W-1:0]            hst_req_wdata,
  input logic                         hst_rsp_valid,
  input logic [DATA_W-1:0]            hst_rsp_rdata,
  input logic                         hst_rsp_err,
  input logic                         slot_req_valid,
  input logic                         slot_req_ready,
  input logic                         slot_req_write,
  input logic [$clog2(SLOT_SPAN)-1:0] slot_req_addr,
  input logic [DATA_W-1:0]            slot_req_wdata,
  input logic                         slot_rst
);

  logic host_fire, to_slot, swr_fire;

  assign host_fire = hst_req_valid && hst_req_ready;
  assign to_slot   = (hst_req_addr[1:0] == 2'b00) &&
                     (32'(hst_req_addr) >= SLOT_BASE) &&
                     (32'(hst_req_addr) < SLOT_BASE + SLOT_SPAN);
  assign swr_fire  = host_fire && hst_req_write &&
                     (hst_req_addr == '0) && hst_req_wdata[0];

  AST_SLOT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (slot_req_valid && !slot_req_ready) |=> (slot_req_valid && $stable(slot_req_addr) && $stable(slot_req_wdata) && $stable(slot_req_write))); // R7
  AST_HOST_STALL: assert property (@(posedge clk) disable iff (!rst_n)
    slot_req_valid |-> !hst_req_ready); // R7
  AST_SLOT_RSP: assert property (@(posedge clk) disable iff (!rst_n)
    (slot_req_valid && slot_req_ready) |=> (hst_rsp_valid && !hst_rsp_err)); // R8
  AST_LOCAL_RSP: assert property (@(posedge clk) disable iff (!rst_n)
    (host_fire && !to_slot) |=> hst_rsp_valid); // R11
  AST_SWR_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    swr_fire |=> slot_rst); // R4
  AST_ERR_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    hst_rsp_err |-> (hst_rsp_valid && (hst_rsp_rdata == '0))); // R9

endmodule

bind sdhost_regfront sdrf_checker #(
  .ADDR_W(ADDR_W), .DATA_W(DATA_W), .SLOT_BASE(SLOT_BASE), .SLOT_SPAN(SLOT_SPAN)
) u_chk (
  .clk(clk), .rst_n(rst_n),
  .hst_req_valid(hst_req_valid), .hst_req_ready(hst_req_ready),
  .hst_req_write(hst_req_write), .hst_req_addr(hst_req_addr),
  .hst_req_wdata(hst_req_wdata), .hst_rsp_valid(hst_rsp_valid),
  .hst_rsp_rdata(hst_rsp_rdata), .hst_rsp_err(hst_rsp_err),
  .slot_req_valid(slot_req_valid), .slot_req_ready(slot_req_ready),
  .slot_req_write(slot_req_write), .slot_req_addr(slot_req_addr),
  .slot_req_wdata(slot_req_wdata), .slot_rst(slot_rst)
);

// File: tb/sim_sdhost_regfront.sv
`timescale 1ns/1ps
module sim_sdhost_regfront;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        hst_req_valid = 1'b0;
  logic        hst_req_ready;
  logic        hst_req_write = 1'b0;
  logic [11:0] hst_req_addr = '0;
  logic [31:0] hst_req_wdata = '0;
  logic        hst_rsp_valid;
  logic [31:0] hst_rsp_rdata;
  logic        hst_rsp_err;
  logic        slot_req_valid;
  logic        slot_req_ready = 1'b0;
  logic        slot_req_write;
  logic [7:0]  slot_req_addr;
  logic [31:0] slot_req_wdata;
  logic [31:0] slot_rsp_rdata = '0;
  logic        slot_irq = 1'b0;
  logic        slot_rst;
  logic        host_irq;

  always #4 clk = ~clk;  // 125 MHz

  sdhost_regfront u0 (.*);

  int checks = 0;
  int failures = 0;
  int cyc = 0;
  bit finished = 1'b0;

  always @(posedge clk) cyc <= cyc + 1;

  typedef struct {
    logic [31:0] data;
    logic        err;
    int          acc;
    bit          fixed;
    string       tag;
  } exp_t;

  exp_t sb[$];

  task automatic check(string tag, logic [31:0] got, logic [31:0] exp);
    checks++;
    if (got !== exp) begin
      failures++;
      $display("FAIL %s: got %h expected %h", tag, got, exp);
    end
  endtask

  // Slot model: small memory, programmable stall before ready.
  logic [31:0] smem [64];
  int          slot_delay = 0;
  int          wait_cnt = 0;
  logic [7:0]  slot_last_addr = '0;

  initial begin
    for (int i = 0; i < 64; i++) smem[i] = '0;
    forever begin
      @(negedge clk);
      if (slot_req_ready) begin
        slot_req_ready = 1'b0;
      end else if (slot_req_valid) begin
        if (wait_cnt >= slot_delay) begin
          slot_last_addr = slot_req_addr;
          if (slot_req_write) smem[slot_req_addr[7:2]] = slot_req_wdata;
          else                slot_rsp_rdata = smem[slot_req_addr[7:2]];
          slot_req_ready = 1'b1;
          wait_cnt = 0;
        end else begin
          wait_cnt++;
        end
      end
    end
  end

  // Monitor: pops expected responses in order.
  initial begin
    forever begin
      @(negedge clk);
      if (rst_n && hst_rsp_valid) begin
        if (sb.size() == 0) begin
          check("unexpected response", 32'd1, 32'd0);
        end else begin
          exp_t e;
          e = sb.pop_front();
          check({e.tag, " rdata"}, hst_rsp_rdata, e.data);
          check({e.tag, " err"}, {31'd0, hst_rsp_err}, {31'd0, e.err});
          if (e.fixed) check({e.tag, " R11 latency"}, cyc, e.acc);
        end
      end
    end
  end

  // Driver: waits for ready at a falling edge, records the expected item.
  task automatic access(bit wr, logic [11:0] a, logic [31:0] d,
                        logic [31:0] exp, bit exp_err, bit fixed, string tag);
    exp_t e;
    hst_req_valid = 1'b1;
    hst_req_write = wr;
    hst_req_addr  = a;
    hst_req_wdata = d;
    while (!hst_req_ready) @(negedge clk);
    e.data = exp; e.err = exp_err; e.acc = cyc + 1; e.fixed = fixed; e.tag = tag;
    sb.push_back(e);
    @(negedge clk);
    hst_req_valid = 1'b0;
  endtask

  task automatic drain();
    while (sb.size() != 0) @(negedge clk);
    @(negedge clk);
  endtask

  task automatic summary();
    if (!finished) begin
      finished = 1'b1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    failures++;
    $display("FAIL watchdog: got timeout expected completion");
    summary();
  end

  initial begin
    repeat (3) @(negedge clk);
    check("R1 slot_rst in reset", {31'd0, slot_rst}, 32'd1);
    rst_n = 1'b1;
    @(negedge clk);
    check("R1 slot_rst after reset", {31'd0, slot_rst}, 32'd0);
    check("R11 ready idle", {31'd0, hst_req_ready}, 32'd1);

    access(0, 12'h000, 0, 32'h0001_0000, 0, 1, "R1 ctrl reset value");
    access(0, 12'h0FC, 0, 32'h0, 0, 1, "R1 last word zero");
    access(0, 12'h010, 0, 32'h0, 0, 1, "R1 phy zero");

    access(1, 12'h020, 32'hDEAD_BEEF, 0, 0, 1, "R2 write");
    access(0, 12'h020, 0, 32'hDEAD_BEEF, 0, 1, "R2 readback");
    access(1, 12'h0FC, 32'h1234_5678, 0, 0, 1, "R2 write top");
    access(0, 12'h0FC, 0, 32'h1234_5678, 0, 1, "R2 readback top");

    access(1, 12'h000, 32'hFFFF_FFFE, 0, 0, 1, "R3 write no swr");
    access(0, 12'h000, 0, 32'h0001_0000, 0, 1, "R3 ctrl unchanged");
    check("R3 no slot reset", {31'd0, slot_rst}, 32'd0);

    access(1, 12'h010, 32'h0100_00FF, 0, 0, 1, "R5 wr req");
    access(0, 12'h010, 0, 32'h0500_00FF, 0, 1, "R5 ack on wr req");
    access(1, 12'h010, 32'h0200_0000, 0, 0, 1, "R5 rd req");
    access(0, 12'h010, 0, 32'h0600_0000, 0, 1, "R5 ack on rd req");
    access(1, 12'h010, 32'h0400_0001, 0, 0, 1, "R5 ack only");
    access(0, 12'h010, 0, 32'h0000_0001, 0, 1, "R5 ack dropped");
    access(1, 12'h010, 32'h0300_0000, 0, 0, 1, "R5 both req");
    access(0, 12'h010, 0, 32'h0700_0000, 0, 1, "R5 ack on both");

    access(1, 12'h018, 32'hFFFF_FFFF, 0, 0, 1, "R6 write all ones");
    access(0, 12'h018, 0, 32'hFFFF_7FFF, 0, 1, "R6 tune cleared");
    access(1, 12'h018, 32'h0000_8000, 0, 0, 1, "R6 tune only");
    access(0, 12'h018, 0, 32'h0, 0, 1, "R6 tune only cleared");

    access(1, 12'h100, 32'h1, 0, 1, 1, "R9 gap write");
    access(0, 12'h1FC, 0, 0, 1, 1, "R9 gap read");
    access(0, 12'h300, 0, 0, 1, 1, "R9 above slot read");
    access(0, 12'h022, 0, 0, 1, 1, "R9 misaligned read");
    access(1, 12'h022, 32'h0, 0, 1, 1, "R9 misaligned write");
    access(0, 12'h020, 0, 32'hDEAD_BEEF, 0, 1, "R9 word untouched");
    access(0, 12'h000, 0, 32'h0001_0000, 0, 1, "R9 ctrl untouched");

    slot_delay = 0;
    access(1, 12'h204, 32'hCAFE_0001, 0, 0, 0, "R8 slot write");
    drain();
    check("R7 slot offset", {24'd0, slot_last_addr}, 32'h04);
    access(0, 12'h204, 0, 32'hCAFE_0001, 0, 0, "R8 slot read");
    drain();

    slot_delay = 3;
    access(1, 12'h2FC, 32'h1111_2222, 0, 0, 0, "R8 slot write stalled");
    check("R7 host stalled", {31'd0, hst_req_ready}, 32'd0);
    drain();
    check("R7 slot offset top", {24'd0, slot_last_addr}, 32'hFC);
    access(0, 12'h2FC, 0, 32'h1111_2222, 0, 0, "R8 slot read stalled");
    check("R7 host stalled read", {31'd0, hst_req_ready}, 32'd0);
    drain();

    access(1, 12'h000, 32'h0000_0001, 0, 0, 1, "R4 swr write");
    check("R4 slot_rst pulse", {31'd0, slot_rst}, 32'd1);
    @(negedge clk);
    check("R4 slot_rst ends", {31'd0, slot_rst}, 32'd0);
    access(0, 12'h020, 0, 32'h0, 0, 1, "R4 word cleared");
    access(0, 12'h010, 0, 32'h0, 0, 1, "R4 phy cleared");
    access(0, 12'h0FC, 0, 32'h0, 0, 1, "R4 top cleared");
    access(0, 12'h000, 0, 32'h0001_0000, 0, 1, "R4 ctrl default");
    drain();

    slot_irq = 1'b1; #1;
    check("R10 irq high", {31'd0, host_irq}, 32'd1);
    slot_irq = 1'b0; #1;
    check("R10 irq low", {31'd0, host_irq}, 32'd0);

    check("scoreboard empty", sb.size(), 0);
    summary();
  end

endmodule